// File: doc/BRIEF.md
# UART Host Register Interface

This block is the register-facing half of a small serial port. A host reaches it through a plain 32-bit register bus with four word addresses. Behind those registers are a transmit byte queue and a receive byte queue. On the far side is a serial engine that does the bit timing and framing. The engine pulls bytes from the transmit queue and pushes received bytes into the receive queue, both with a valid/ready handshake. The block also hands the engine its line configuration: whether the link is on, which parity to use, and whether to hold the line in break.

One register carries both directions of data. On a read, its two flag bits report whether the transmit queue can take a byte and whether a received byte sits in the low eight bits. On a write, the same flag bits act as commands. Setting the transmit flag queues the low byte. Setting the receive flag discards the byte at the head of the receive queue. The framing is fixed at eight data bits and one stop bit. Only none, even and odd parity exist.

Interrupts are handled in two levels. A status register with write-one-to-clear bits records a receive-data event and a transmit-drained event. A per-source enable register masks those events. The masked events are OR-ed into a summary bit in the control register. A separate host enable bit then gates that summary onto the interrupt pin.

Top module: `uart_host_if`

## Requirements
- R1: After reset, the control, status and enable registers read zero, irq and link_en are low, and the data register reads 0x200: bit 9 (transmit can accept) is 1, bit 8 (receive valid) is 0, and bits 7:0 are 0.
- R2: A write to address 0 with bit 9 set queues wdata[7:0] in the transmit queue. Queued bytes appear on eng_tx_data in the order they were written, one per accepted eng_tx_valid/eng_tx_ready handshake.
- R3: Address 0 bit 9 reads 1 exactly when the transmit queue is not full (depth TX_DEPTH, default 4). A queue request while the queue is full is dropped and leaves the queued bytes unchanged.
- R4: Address 0 bit 8 reads 1 when the receive queue holds a byte, and bits 7:0 then show the oldest byte (they read 0 when the queue is empty). A write with bit 8 set discards that byte. A discard request on an empty queue has no effect.
- R5: Status register (address 2) bit 0 is set on every cycle in which the receive queue is non-empty. Writing 1 to a status bit clears it, but a set in the same cycle wins over the clear.
- R6: Status bit 1 is set in the cycle after the engine takes the last byte out of the transmit queue.
- R7: Control bit 6 reads the OR of (status AND enable register at address 3, bits 1:0), whatever the host enable is. irq is high only when control bit 5 (host enable) is 1 and that OR is 1.
- R8: Control bits 1:0 select the interface mode. Value 0 turns the link off: link_en, eng_tx_valid and eng_rx_ready are held low. Any non-zero value, for example the DCE code 2, turns the link on.
- R9: Control bits 3:2 select parity: 0 is none, 1 is even, 2 is odd. A write of 3 (an unsupported parity) is stored as 0. The field drives parity_sel.
- R10: Control bit 4 is the break request and drives brk_force directly.
- R11: eng_rx_ready is low while the receive queue is full (depth RX_DEPTH, default 4). A byte offered then is lost, and the queued bytes stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 data, 1 control, 2 status, 3 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Host interrupt |
| eng_tx_data | output | 8 | Byte at the head of the transmit queue |
| eng_tx_valid | output | 1 | Transmit byte available and link on |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_rx_data | input | 8 | Received byte from the engine |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | Receive queue has room and link on |
| link_en | output | 1 | Interface mode is non-zero |
| parity_sel | output | 2 | 0 none, 1 even, 2 odd |
| brk_force | output | 1 | Hold the transmit line at break level |

## Verification
The checker watches several rules on every cycle. It confirms that the pin stays quiet while the host enable is off, and that both engine handshakes stay shut while the mode field is zero. It also confirms that a full transmit queue or an empty receive queue is left alone by requests it must ignore. The receive and drain status bits are checked one cycle after their causes. Byte ordering through both queues, the parity encoding rule, the set-over-clear contest in the status register, and the dropping of surplus bytes can only be seen in the bench's scripted sequences, which compare values read back against values written.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;

  localparam int NSRC   = 2;
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;

  localparam int DB_RXF = 8;
  localparam int DB_TXF = 9;

  typedef enum logic [1:0] {
    RA_DATA  = 2'd0,
    RA_CTRL  = 2'd1,
    RA_STAT  = 2'd2,
    RA_INTEN = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } parity_e;

  localparam logic [1:0] MODE_OFF = 2'd0;
  localparam logic [1:0] MODE_DCE = 2'd2;

  typedef struct packed {
    logic       host_ie;
    logic       brk;
    parity_e    par;
    logic [1:0] mode;
  } ctrl_t;

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int SUM_BIT = CTRL_W;

endpackage

// File: rtl/host_byte_fifo.sv
module host_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    cnt_o,
  output logic             empty_o,
  output logic             full_o
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_d  = push_ok ? bump(wr_q) : wr_q;
    rd_d  = pop_ok  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push_ok && !pop_ok) cnt_d = cnt_q + CW'(1);
    if (pop_ok && !push_ok) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata_i;
  end

  assign rdata_o = mem[rd_q];
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg
  import uart_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl_o
);

  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d = ctrl_t'(wdata);
      if (wdata[3:2] == 2'b11) ctrl_d.par = PAR_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_wr,
  input  logic            en_wr,
  input  logic [NSRC-1:0] wbits,
  input  logic [NSRC-1:0] set_i,
  input  logic            host_ie,
  output logic [NSRC-1:0] stat_o,
  output logic [NSRC-1:0] en_o,
  output logic            summary_o,
  output logic            irq_o
);

  logic [NSRC-1:0] stat_q, stat_d, en_q, en_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb begin
      stat_d[i] = set_i[i] | (stat_q[i] & ~(stat_wr & wbits[i]));
      en_d[i]   = en_wr ? wbits[i] : en_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  assign stat_o    = stat_q;
  assign en_o      = en_q;
  assign summary_o = |(stat_q & en_q);
  assign irq_o     = summary_o & host_ie;

endmodule

// File: rtl/uart_host_if.sv
module uart_host_if
  import uart_host_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int TXCW = $clog2(TX_DEPTH + 1),
  localparam int RXCW = $clog2(RX_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic [7:0]  eng_tx_data,
  output logic        eng_tx_valid,
  input  logic        eng_tx_ready,
  input  logic [7:0]  eng_rx_data,
  input  logic        eng_rx_valid,
  output logic        eng_rx_ready,
  output logic        link_en,
  output logic [1:0]  parity_sel,
  output logic        brk_force
);

  // reset: asserted asynchronously, released on clock
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  // bus decode
  logic wr_data, wr_ctrl, wr_stat, wr_en;
  assign wr_data = bus_we && (bus_addr == RA_DATA);
  assign wr_ctrl = bus_we && (bus_addr == RA_CTRL);
  assign wr_stat = bus_we && (bus_addr == RA_STAT);
  assign wr_en   = bus_we && (bus_addr == RA_INTEN);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[31:10];

  // control register
  ctrl_t ctrl;
  uart_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_ns),
    .wr_en  (wr_ctrl),
    .wdata  (bus_wdata[CTRL_W-1:0]),
    .ctrl_o (ctrl)
  );

  assign link_en    = (ctrl.mode != MODE_OFF);
  assign parity_sel = ctrl.par;
  assign brk_force  = ctrl.brk;

  // transmit queue
  logic [TXCW-1:0] tx_cnt;
  logic            tx_empty, tx_full, tx_push, tx_pop, tx_drained;

  assign tx_push = wr_data && bus_wdata[DB_TXF];
  assign tx_pop  = eng_tx_valid && eng_tx_ready;

  host_byte_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk     (clk),
    .rst_n   (rst_ns),
    .push_i  (tx_push),
    .pop_i   (tx_pop),
    .wdata_i (bus_wdata[7:0]),
    .rdata_o (eng_tx_data),
    .cnt_o   (tx_cnt),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  assign eng_tx_valid = link_en && !tx_empty;
  assign tx_drained   = tx_pop && (tx_cnt == TXCW'(1)) && !(tx_push && !tx_full);

  // receive queue
  logic [RXCW-1:0] rx_cnt;
  logic [7:0]      rx_head;
  logic            rx_empty, rx_full, rx_push, rx_pop;

  assign rx_pop       = wr_data && bus_wdata[DB_RXF];
  assign eng_rx_ready = link_en && !rx_full;
  assign rx_push      = eng_rx_valid && eng_rx_ready;

  host_byte_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_ns),
    .push_i  (rx_push),
    .pop_i   (rx_pop),
    .wdata_i (eng_rx_data),
    .rdata_o (rx_head),
    .cnt_o   (rx_cnt),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  // interrupts
  logic [NSRC-1:0] int_set, int_stat, int_en;
  logic            int_sum;

  always_comb begin
    int_set         = '0;
    int_set[SRC_RX] = !rx_empty;
    int_set[SRC_TX] = tx_drained;
  end

  uart_irq_unit #(.NSRC(NSRC)) u_irq (
    .clk       (clk),
    .rst_n     (rst_ns),
    .stat_wr   (wr_stat),
    .en_wr     (wr_en),
    .wbits     (bus_wdata[NSRC-1:0]),
    .set_i     (int_set),
    .host_ie   (ctrl.host_ie),
    .stat_o    (int_stat),
    .en_o      (int_en),
    .summary_o (int_sum),
    .irq_o     (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      RA_DATA: begin
        bus_rdata[7:0]    = rx_empty ? 8'h00 : rx_head;
        bus_rdata[DB_RXF] = !rx_empty;
        bus_rdata[DB_TXF] = !tx_full;
      end
      RA_CTRL: begin
        bus_rdata[CTRL_W-1:0] = ctrl;
        bus_rdata[SUM_BIT]    = int_sum;
      end
      RA_STAT:  bus_rdata[NSRC-1:0] = int_stat;
      RA_INTEN: bus_rdata[NSRC-1:0] = int_en;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_host_if_chk.sv
module uart_host_if_chk #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int TXCW = $clog2(TX_DEPTH + 1),
  localparam int RXCW = $clog2(RX_DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_ns,
  input logic            irq,
  input logic            host_ie,
  input logic            link_en,
  input logic            eng_tx_valid,
  input logic            eng_tx_ready,
  input logic            eng_rx_valid,
  input logic            eng_rx_ready,
  input logic            data_wr,
  input logic            tx_flag_w,
  input logic [TXCW-1:0] tx_cnt,
  input logic [RXCW-1:0] rx_cnt,
  input logic [1:0]      int_stat
);

  localparam logic [TXCW-1:0] TX_FULL = TXCW'(TX_DEPTH);
  localparam logic [RXCW-1:0] RX_FULL = RXCW'(RX_DEPTH);

  // R7
  host_gate_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !host_ie |-> !irq);

  // R8
  link_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !link_en |-> (!eng_tx_valid && !eng_rx_ready));

  // R3
  tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (tx_cnt == TX_FULL && !(eng_tx_valid && eng_tx_ready)) |=> (tx_cnt == TX_FULL));

  // R4
  rx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (rx_cnt == '0 && !(eng_rx_valid && eng_rx_ready)) |=> (rx_cnt == '0));

  // R5
  rx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (rx_cnt != '0) |=> int_stat[0]);

  // R6
  tx_drain_set_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (tx_cnt == TXCW'(1) && eng_tx_valid && eng_tx_ready && !(data_wr && tx_flag_w))
      |=> int_stat[1]);

  // R11
  rx_full_block_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (rx_cnt == RX_FULL) |-> !eng_rx_ready);

endmodule

bind uart_host_if uart_host_if_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk          (clk),
  .rst_ns       (rst_ns),
  .irq          (irq),
  .host_ie      (ctrl.host_ie),
  .link_en      (link_en),
  .eng_tx_valid (eng_tx_valid),
  .eng_tx_ready (eng_tx_ready),
  .eng_rx_valid (eng_rx_valid),
  .eng_rx_ready (eng_rx_ready),
  .data_wr      (wr_data),
  .tx_flag_w    (bus_wdata[9]),
  .tx_cnt       (tx_cnt),
  .rx_cnt       (rx_cnt),
  .int_stat     (int_stat)
);

// File: tb/uart_host_if_tb_top.sv
`timescale 1ns/1ps
module uart_host_if_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [7:0]  eng_tx_data;
  logic        eng_tx_valid;
  logic        eng_tx_ready;
  logic [7:0]  eng_rx_data;
  logic        eng_rx_valid;
  logic        eng_rx_ready;
  logic        link_en;
  logic [1:0]  parity_sel;
  logic        brk_force;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  uart_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
    .eng_rx_data(eng_rx_data), .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready),
    .link_en(link_en), .parity_sel(parity_sel), .brk_force(brk_force)
  );

  typedef struct packed {
    logic [1:0]  addr;
    logic [31:0] wr;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd1, 32'h0000_0002, 32'h0000_0002},   // R8 DCE mode
    '{2'd1, 32'h0000_0006, 32'h0000_0006},   // R9 even
    '{2'd1, 32'h0000_000A, 32'h0000_000A},   // R9 odd
    '{2'd1, 32'h0000_000E, 32'h0000_0002},   // R9 unsupported -> none
    '{2'd1, 32'h0000_0012, 32'h0000_0012},   // R10 break
    '{2'd1, 32'h0000_0022, 32'h0000_0022},   // R7 host enable
    '{2'd3, 32'hFFFF_FFFF, 32'h0000_0003},   // R7 enable register
    '{2'd3, 32'h0000_0000, 32'h0000_0000}    // R7 enable register
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic eng_give(input logic [7:0] b);
    @(negedge clk);
    eng_rx_valid = 1'b1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  task automatic eng_take(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, {23'b0, eng_tx_valid, eng_tx_data}, {23'b0, 1'b1, exp});
    eng_tx_ready = 1'b1;
    @(negedge clk);
    eng_tx_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    eng_tx_ready = 1'b0; eng_rx_valid = 1'b0; eng_rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(2'd0, v); check("R1 data", v, 32'h200);
    bus_rd(2'd1, v); check("R1 ctrl", v, 32'h0);
    bus_rd(2'd2, v); check("R1 stat", v, 32'h0);
    bus_rd(2'd3, v); check("R1 inten", v, 32'h0);
    check("R1 pins", {28'b0, irq, link_en, eng_tx_valid, eng_rx_ready}, 32'h0);

    // table walk over control and enable registers
    for (int i = 0; i < 8; i++) begin
      bus_wr(VEC[i].addr, VEC[i].wr);
      bus_rd(VEC[i].addr, v);
      check($sformatf("R9/R7 vector %0d", i), v, VEC[i].exp);
      if (i == 2) check("R9 parity_sel odd", {30'b0, parity_sel}, 32'h2);
    end
    bus_wr(2'd1, 32'h0);

    // R10 break
    bus_wr(2'd1, 32'h10);
    check("R10 brk on", {31'b0, brk_force}, 32'h1);
    bus_wr(2'd1, 32'h0);
    check("R10 brk off", {31'b0, brk_force}, 32'h0);

    // R8 link off holds the queue back
    bus_wr(2'd0, 32'h241);
    @(negedge clk);
    check("R8 off quiet", {30'b0, link_en, eng_tx_valid}, 32'h0);
    bus_wr(2'd1, 32'h2);
    check("R8 on", {30'b0, link_en, eng_tx_valid}, 32'h3);

    // R2 ordering
    bus_wr(2'd0, 32'h242);
    bus_wr(2'd0, 32'h243);
    eng_take("R2 byte0", 8'h41);
    eng_take("R2 byte1", 8'h42);
    eng_take("R2 byte2", 8'h43);
    // R6 drained
    bus_rd(2'd2, v); check("R6 drain status", v, 32'h2);

    // R7 two-level interrupt
    bus_wr(2'd3, 32'h2);
    bus_rd(2'd1, v); check("R7 summary visible", v, 32'h42);
    check("R7 irq gated", {31'b0, irq}, 32'h0);
    bus_wr(2'd1, 32'h22);
    check("R7 irq on", {31'b0, irq}, 32'h1);
    bus_wr(2'd2, 32'h2);
    check("R7 irq cleared", {31'b0, irq}, 32'h0);
    bus_rd(2'd2, v); check("R5 w1c", v, 32'h0);

    // R3 full transmit queue drops extra byte
    for (int i = 0; i < 4; i++) bus_wr(2'd0, 32'h250 + 32'(i));
    bus_rd(2'd0, v); check("R3 full flag", v, 32'h0);
    bus_wr(2'd0, 32'h2EE);
    for (int i = 0; i < 4; i++) eng_take("R3 drain", 8'h50 + 8'(i));
    @(negedge clk);
    check("R3 extra dropped", {31'b0, eng_tx_valid}, 32'h0);
    bus_wr(2'd2, 32'h2);

    // R4 / R5 receive path
    eng_give(8'h11);
    eng_give(8'h22);
    bus_rd(2'd0, v); check("R4 head", v, 32'h311);
    bus_rd(2'd2, v); check("R5 rx status", v, 32'h1);
    bus_wr(2'd2, 32'h1);
    bus_rd(2'd2, v); check("R5 set wins", v, 32'h1);
    bus_wr(2'd0, 32'h100);
    bus_rd(2'd0, v); check("R4 second", v, 32'h322);
    bus_wr(2'd0, 32'h100);
    bus_rd(2'd0, v); check("R4 empty", v, 32'h200);
    bus_wr(2'd0, 32'h100);
    bus_rd(2'd0, v); check("R4 pop on empty", v, 32'h200);
    eng_give(8'h33);
    bus_rd(2'd0, v); check("R4 after empty pop", v, 32'h333);
    bus_wr(2'd0, 32'h100);
    bus_wr(2'd2, 32'h1);
    bus_rd(2'd2, v); check("R5 cleared", v, 32'h0);

    // R11 full receive queue
    for (int i = 0; i < 4; i++) eng_give(8'h60 + 8'(i));
    @(negedge clk);
    check("R11 ready low", {31'b0, eng_rx_ready}, 32'h0);
    eng_give(8'h99);
    for (int i = 0; i < 4; i++) begin
      bus_rd(2'd0, v); check("R11 kept", v, 32'h360 + 32'(i));
      bus_wr(2'd0, 32'h100);
    end
    bus_rd(2'd0, v); check("R11 extra lost", v, 32'h200);

    // R8 mode zero again
    bus_wr(2'd1, 32'h0);
    check("R8 off again", {30'b0, link_en, eng_rx_ready}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule